// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Controller

This block sits on the host side of a 16-bit parallel NOR flash bus and carries out single program and erase requests. A request names one of four operations (program one word, erase one sector, erase one block, erase the whole chip), a word address and a data word. The controller drives the unlock and command write cycles that the flash's write protection requires. It then reads the target location repeatedly until the device reports that the internal operation has finished, and ends each request with a one-cycle `done` or `error` pulse.

Completion is judged from two status bits in every poll read. Bit 7 is the Data# indicator: while the device is busy it reads as the inverse of the final value's bit 7. Bit 6 is the toggle indicator: while the device is busy it changes on every read. When both indicators agree, the controller acts on them at once. When they disagree, which can happen if a read lands on the moment the device finishes, the controller reads the location twice more and accepts the write only if both reads return the expected word. A cycle-count limit for each operation class bounds the polling. When the limit runs out, the controller writes the reset command to return the flash to read mode and then reports a timeout error.

The state machine has nine states. `S_IDLE` waits for a request. `S_CMD` issues one bus write per cycle. `S_POLL_RD` and `S_POLL_EV` issue a status read and then judge it. `S_CONF_RD` and `S_CONF_EV` carry out the two confirming reads. `S_EXIT` writes the reset command. `S_FIN_OK` and `S_FIN_ERR` are the report states. The transitions are:
- IDLE→CMD when a request is accepted.
- CMD→POLL_RD after the last command write.
- POLL_RD→POLL_EV when a read is issued, or POLL_RD→EXIT when the limit has expired.
- POLL_EV→POLL_RD when the device is busy, POLL_EV→FIN_OK when it is done and the word matches, POLL_EV→FIN_ERR when it is done and the word differs, and POLL_EV→CONF_RD on a conflict.
- CONF_RD→CONF_EV.
- CONF_EV→CONF_RD after the first good confirming read, CONF_EV→FIN_OK after the second, and CONF_EV→FIN_ERR on a bad one.
- EXIT→FIN_ERR.
- FIN_OK/FIN_ERR→IDLE.

Top module: `nor_pe_ctrl`

## Requirements
- R1: After reset, and whenever it is idle, the controller holds `ready` high and keeps `bus_wr`, `bus_rd`, `done` and `error` low.
- R2: A program request (`req_op`=0) produces four bus writes on consecutive cycles, starting the cycle after acceptance: 00AAh to 5555h, 0055h to 2AAAh, 00A0h to 5555h, then the request data to the request address.
- R3: An erase request produces six consecutive writes: AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h, 55h/2AAAh, then a final write. The final write is 30h to the request address for a sector erase (`req_op`=1), 50h to the request address for a block erase (`req_op`=2), or 10h to 5555h for a chip erase (`req_op`=3).
- R4: After the last command write the controller polls by pulsing `bus_rd` for one cycle with the request address on `bus_addr`. It takes `bus_rdata` in the following cycle and never drives `bus_rd` and `bus_wr` together. The expected word is the request data for a program and FFFFh for an erase.
- R5: The first poll read only records bit 6. On each later poll read, bit 7 reports done when it equals the expected word's bit 7, and bit 6 reports done when it equals the previous read's bit 6. If both report done, `done` pulses when the read equals the expected word; otherwise `error` pulses with `err_timeout` low, which is a verify failure.
- R6: If exactly one indicator reports done, the location is read two more times. `done` pulses only if both reads equal the expected word; otherwise `error` pulses with `err_timeout` low.
- R7: If polling is still running when the limit has expired (`PGM_TMO` cycles for a program, `ERS_TMO` for a sector or block erase, `CHIP_TMO` for a chip erase), the controller writes 00F0h to 5555h and then pulses `error` with `err_timeout` high.
- R8: `ready` stays low from the cycle after acceptance until the `done` or `error` pulse. While it is low, `req_valid` has no effect on the bus.
- R9: `done` and `error` are one-cycle pulses that never coincide, and `ready` is high in the cycle after either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; accepted while `ready` is high |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target word address |
| req_data | input | 16 | Word to program |
| ready | output | 1 | Controller idle, can accept a request |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| err_timeout | output | 1 | With `error`: 1 timeout, 0 verify failure |
| bus_addr | output | AW | Flash word address |
| bus_wdata | output | 16 | Flash write data |
| bus_wr | output | 1 | Write strobe, one write per high cycle |
| bus_rd | output | 1 | Read strobe, data returned next cycle |
| bus_rdata | input | 16 | Flash read data |

## Verification
The bench pairs a behavioural flash model with a reference model. The flash model returns busy patterns, read glitches at the moment of completion, and cells that cannot go from 0 to 1. The corner cases it targets are these:
- A program over 0 bits, which a controller that skips the word compare would wrongly report as done.
- A read whose bit 6 conflicts at completion. A design without the confirming reads would either report done early or, if it ignored the conflict, keep polling.
- A confirming read that returns a wrong word, which must turn into a rejection.
- A device stuck busy. A missing or mis-selected timeout would hang, or would leave out the F0h reset write.

Requests held on `req_valid` during busy periods would show up as extra writes against the expected write queue.

// File: rtl/nor_pe_pkg.sv
package nor_pe_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_POLL_RD,
        S_POLL_EV,
        S_CONF_RD,
        S_CONF_EV,
        S_EXIT,
        S_FIN_OK,
        S_FIN_ERR
    } state_e;

    typedef enum logic [1:0] {
        PV_BUSY,
        PV_OK,
        PV_BAD,
        PV_CONFLICT
    } verdict_e;

    localparam logic [15:0] ADDR_KEY1  = 16'h5555;
    localparam logic [15:0] ADDR_KEY2  = 16'h2AAA;
    localparam logic [15:0] DAT_KEY1   = 16'h00AA;
    localparam logic [15:0] DAT_KEY2   = 16'h0055;
    localparam logic [15:0] DAT_PROG   = 16'h00A0;
    localparam logic [15:0] DAT_ESETUP = 16'h0080;
    localparam logic [15:0] DAT_SECT   = 16'h0030;
    localparam logic [15:0] DAT_BLK    = 16'h0050;
    localparam logic [15:0] DAT_CHIP   = 16'h0010;
    localparam logic [15:0] DAT_RESET  = 16'h00F0;

endpackage

// File: rtl/nor_pe_seq.sv
module nor_pe_seq
    import nor_pe_pkg::*;
#(
    parameter int AW = 20
) (
    input  op_e            op,
    input  logic [2:0]     idx,
    input  logic [AW-1:0]  tgt_addr,
    input  logic [15:0]    tgt_data,
    output logic [AW-1:0]  wr_addr,
    output logic [15:0]    wr_data,
    output logic           last
);
    localparam logic [2:0] PROG_LAST = 3'd3;
    localparam logic [2:0] ERS_LAST  = 3'd5;

    logic [AW-1:0] k1, k2;
    assign k1 = AW'(ADDR_KEY1);
    assign k2 = AW'(ADDR_KEY2);

    always_comb begin
        wr_addr = k1;
        wr_data = DAT_KEY1;
        if (op == OP_PROG) begin
            last = (idx == PROG_LAST);
            unique case (idx)
                3'd0:    begin wr_addr = k1;       wr_data = DAT_KEY1; end
                3'd1:    begin wr_addr = k2;       wr_data = DAT_KEY2; end
                3'd2:    begin wr_addr = k1;       wr_data = DAT_PROG; end
                default: begin wr_addr = tgt_addr; wr_data = tgt_data; end
            endcase
        end else begin
            last = (idx == ERS_LAST);
            unique case (idx)
                3'd0, 3'd3: begin wr_addr = k1; wr_data = DAT_KEY1;   end
                3'd1, 3'd4: begin wr_addr = k2; wr_data = DAT_KEY2;   end
                3'd2:       begin wr_addr = k1; wr_data = DAT_ESETUP; end
                default: begin
                    unique case (op)
                        OP_SECT: begin wr_addr = tgt_addr; wr_data = DAT_SECT; end
                        OP_BLK:  begin wr_addr = tgt_addr; wr_data = DAT_BLK;  end
                        default: begin wr_addr = k1;       wr_data = DAT_CHIP; end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/nor_pe_poll.sv
module nor_pe_poll
    import nor_pe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        sample,
    input  logic [15:0] rdata,
    input  logic [15:0] expect_word,
    output verdict_e    verdict
);
    logic prev6;
    logic have_prev;
    logic dpoll_done;
    logic toggle_done;

    assign dpoll_done  = (rdata[7] == expect_word[7]);
    assign toggle_done = have_prev && (rdata[6] == prev6);

    always_comb begin
        if (!have_prev)
            verdict = PV_BUSY;
        else if (dpoll_done && toggle_done)
            verdict = (rdata == expect_word) ? PV_OK : PV_BAD;
        else if (!dpoll_done && !toggle_done)
            verdict = PV_BUSY;
        else
            verdict = PV_CONFLICT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev6     <= 1'b0;
            have_prev <= 1'b0;
        end else if (clear) begin
            prev6     <= 1'b0;
            have_prev <= 1'b0;
        end else if (sample) begin
            prev6     <= rdata[6];
            have_prev <= 1'b1;
        end
    end
endmodule

// File: rtl/nor_pe_timer.sv
module nor_pe_timer
    import nor_pe_pkg::*;
#(
    parameter int PGM_TMO  = 2000,
    parameter int ERS_TMO  = 20000,
    parameter int CHIP_TMO = 80000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  op_e  op,
    output logic expired
);
    localparam int MAXA = (PGM_TMO > ERS_TMO) ? PGM_TMO : ERS_TMO;
    localparam int MAXL = (MAXA > CHIP_TMO) ? MAXA : CHIP_TMO;
    localparam int CW   = $clog2(MAXL + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (op)
            OP_PROG:         lim = CW'(PGM_TMO);
            OP_SECT, OP_BLK: lim = CW'(ERS_TMO);
            default:         lim = CW'(CHIP_TMO);
        endcase
    end

    assign expired = (cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/nor_pe_ctrl.sv
module nor_pe_ctrl
    import nor_pe_pkg::*;
#(
    parameter int AW       = 20,
    parameter int PGM_TMO  = 2000,
    parameter int ERS_TMO  = 20000,
    parameter int CHIP_TMO = 80000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_data,
    output logic          ready,
    output logic          done,
    output logic          error,
    output logic          err_timeout,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_wdata,
    output logic          bus_wr,
    output logic          bus_rd,
    input  logic [15:0]   bus_rdata
);
    state_e        state, state_nx;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [15:0]   data_q;
    logic [2:0]    idx_q;
    logic          conf_q;
    logic          tmo_q;

    logic [AW-1:0] seq_addr;
    logic [15:0]   seq_data;
    logic          seq_last;
    logic [15:0]   expect_word;
    verdict_e      verdict;
    logic          expired;

    assign expect_word = (op_q == OP_PROG) ? data_q : 16'hFFFF;

    nor_pe_seq #(.AW(AW)) u_seq (
        .op       (op_q),
        .idx      (idx_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .wr_addr  (seq_addr),
        .wr_data  (seq_data),
        .last     (seq_last)
    );

    nor_pe_poll u_poll (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (state == S_CMD),
        .sample      (state == S_POLL_EV),
        .rdata       (bus_rdata),
        .expect_word (expect_word),
        .verdict     (verdict)
    );

    nor_pe_timer #(
        .PGM_TMO  (PGM_TMO),
        .ERS_TMO  (ERS_TMO),
        .CHIP_TMO (CHIP_TMO)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == S_CMD),
        .run     ((state == S_POLL_RD) || (state == S_POLL_EV)),
        .op      (op_q),
        .expired (expired)
    );

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_nx = S_CMD;
            S_CMD:     if (seq_last) state_nx = S_POLL_RD;
            S_POLL_RD: state_nx = expired ? S_EXIT : S_POLL_EV;
            S_POLL_EV: begin
                unique case (verdict)
                    PV_BUSY:     state_nx = S_POLL_RD;
                    PV_OK:       state_nx = S_FIN_OK;
                    PV_BAD:      state_nx = S_FIN_ERR;
                    default:     state_nx = S_CONF_RD;
                endcase
            end
            S_CONF_RD: state_nx = S_CONF_EV;
            S_CONF_EV: begin
                if (bus_rdata != expect_word) state_nx = S_FIN_ERR;
                else if (conf_q)              state_nx = S_FIN_OK;
                else                          state_nx = S_CONF_RD;
            end
            S_EXIT:    state_nx = S_FIN_ERR;
            S_FIN_OK:  state_nx = S_IDLE;
            S_FIN_ERR: state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            idx_q  <= '0;
            conf_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q   <= op_e'(req_op);
                    addr_q <= req_addr;
                    data_q <= req_data;
                    idx_q  <= '0;
                    tmo_q  <= 1'b0;
                end
                S_CMD:     idx_q  <= idx_q + 3'd1;
                S_POLL_EV: conf_q <= 1'b0;
                S_CONF_EV: conf_q <= 1'b1;
                S_EXIT:    tmo_q  <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready       = (state == S_IDLE);
        done        = (state == S_FIN_OK);
        error       = (state == S_FIN_ERR);
        err_timeout = (state == S_FIN_ERR) && tmo_q;
        bus_addr    = '0;
        bus_wdata   = '0;
        bus_wr      = 1'b0;
        bus_rd      = 1'b0;
        unique case (state)
            S_CMD: begin
                bus_wr    = 1'b1;
                bus_addr  = seq_addr;
                bus_wdata = seq_data;
            end
            S_POLL_RD: begin
                bus_rd   = !expired;
                bus_addr = addr_q;
            end
            S_CONF_RD: begin
                bus_rd   = 1'b1;
                bus_addr = addr_q;
            end
            S_EXIT: begin
                bus_wr    = 1'b1;
                bus_addr  = AW'(ADDR_KEY1);
                bus_wdata = DAT_RESET;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nor_pe_chk.sv
module nor_pe_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          ready,
    input logic          done,
    input logic          error,
    input logic          err_timeout,
    input logic [AW-1:0] bus_addr,
    input logic [15:0]   bus_wdata,
    input logic          bus_wr,
    input logic          bus_rd
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!bus_wr && !bus_rd && !done && !error));

    // R2
    accept_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> (bus_wr && !ready && bus_wdata == 16'h00AA
                                  && bus_addr == AW'(16'h5555)));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R5
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_rd, 2));

    // R7
    tmo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && err_timeout) |-> ($past(bus_wr) && $past(bus_wdata) == 16'h00F0));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !done && !error) |=> !ready);

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R9
    pulse_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> (ready && !done && !error));
endmodule

bind nor_pe_ctrl nor_pe_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .ready       (ready),
    .done        (done),
    .error       (error),
    .err_timeout (err_timeout),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd)
);

// File: tb/nor_pe_ctrl_bench.sv
module nor_pe_ctrl_bench;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic          ready, done, error, err_timeout;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata;
    logic          bus_wr, bus_rd;
    logic [15:0]   bus_rdata = 16'h0000;

    always #5 clk = ~clk;

    nor_pe_ctrl #(.AW(AW), .PGM_TMO(200), .ERS_TMO(400), .CHIP_TMO(800)) u_nor_pe_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .ready(ready), .done(done),
        .error(error), .err_timeout(err_timeout), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // reference: expected bus writes, busy tracking
    int wq_addr[$];
    int wq_data[$];
    int tgt = 0;
    bit mbusy = 0;

    // flash model state
    logic [15:0] mem [int];
    int  used[$];
    int  dev_busy = 0;
    int  dev_mode = 0;
    int  glitch = 0;
    bit  tog = 0;
    bit  last6 = 0;

    function automatic logic [15:0] rd_cell(int a);
        return mem.exists(a) ? mem[a] : 16'hFFFF;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // device read port
    always @(posedge clk) begin
        if (bus_rd) begin
            logic [15:0] v, r;
            v = rd_cell(int'(bus_addr));
            r = v;
            if (dev_busy > 0) begin
                dev_busy--;
                r[7] = ~v[7];
                r[6] = tog;
                tog  = ~tog;
            end else if ((dev_mode == 1 || dev_mode == 2) && glitch == 0) begin
                r[6]   = ~last6;
                glitch = 1;
            end else if (dev_mode == 2) begin
                r = v ^ 16'h0001;
            end
            last6 = r[6];
            bus_rdata <= r;
        end
    end

    // reference busy tracking
    always @(posedge clk) begin
        if (!rst_n) mbusy <= 0;
        else if (ready && req_valid) mbusy <= 1;
        else if (done || error) mbusy <= 0;
    end

    // per-cycle comparison
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(ready == !mbusy, "R8", "ready", ready, !mbusy);
            if (bus_wr) begin
                if (wq_addr.size() == 0) begin
                    chk(0, "R8", "unexpected write", int'(bus_wdata), 0);
                end else begin
                    int ea, ed;
                    ea = wq_addr.pop_front();
                    ed = wq_data.pop_front();
                    chk(int'(bus_addr) == ea, "R3", "write addr", int'(bus_addr), ea);
                    chk(int'(bus_wdata) == ed, "R2", "write data", int'(bus_wdata), ed);
                end
            end
            if (bus_rd)
                chk(int'(bus_addr) == tgt, "R4", "poll addr", int'(bus_addr), tgt);
            if (!mbusy)
                chk(!bus_wr && !bus_rd, "R1", "idle bus", {bus_wr, bus_rd}, 0);
        end
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic push_w(int a, int d);
        wq_addr.push_back(a);
        wq_data.push_back(d);
    endtask

    // op: 0 prog,1 sector,2 block,3 chip; mode: 0 normal,1 good glitch,2 bad glitch,3 stuck
    task automatic run_req(int op, int a, int d, int busyn, int mode,
                           bit exp_ok, bit exp_tmo, string req);
        int n;
        push_w(32'h5555, 16'h00AA);
        push_w(32'h2AAA, 16'h0055);
        if (op == 0) begin
            push_w(32'h5555, 16'h00A0);
            push_w(a, d);
            mem[a] = rd_cell(a) & d[15:0];
            used.push_back(a);
        end else begin
            push_w(32'h5555, 16'h0080);
            push_w(32'h5555, 16'h00AA);
            push_w(32'h2AAA, 16'h0055);
            if (op == 1) push_w(a, 16'h0030);
            else if (op == 2) push_w(a, 16'h0050);
            else push_w(32'h5555, 16'h0010);
            foreach (used[i]) begin
                if (op == 3 || (op == 1 && (used[i] >> 11) == (a >> 11)) ||
                    (op == 2 && (used[i] >> 15) == (a >> 15)))
                    mem[used[i]] = 16'hFFFF;
            end
        end
        if (exp_tmo) push_w(32'h5555, 16'h00F0);
        tgt      = a;
        dev_busy = (mode == 3) ? 1000000 : busyn;
        dev_mode = (mode == 3) ? 0 : mode;
        glitch   = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op[1:0];
        req_addr  = a[AW-1:0];
        req_data  = d[15:0];
        @(negedge clk);
        // stray request while busy must have no effect (R8)
        req_op   = 2'd3;
        req_addr = 20'h12345;
        for (int k = 0; k < 5; k++) begin
            if (done || error) break;
            @(negedge clk);
        end
        req_valid = 1'b0;
        n = 0;
        while (!(done || error) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == exp_ok, req, "done", done, exp_ok);
        chk(error == !exp_ok, req, "error", error, !exp_ok);
        if (!exp_ok)
            chk(err_timeout == exp_tmo, req, "err_timeout", err_timeout, exp_tmo);
        @(negedge clk);
        chk(ready && !done && !error, "R9", "pulse end", {ready, done, error}, 3'b100);
        chk(wq_addr.size() == 0, "R2", "writes left", wq_addr.size(), 0);
        wq_addr.delete();
        wq_data.delete();
        dev_busy = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1", "ready in reset", ready, 1);
        chk(!done && !error, "R1", "pulses in reset", {done, error}, 0);
        chk(!bus_wr && !bus_rd, "R1", "strobes in reset", {bus_wr, bus_rd}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ready == 1'b1, "R1", "ready after reset", ready, 1);

        // R2 R5 program with busy period
        run_req(0, 32'h00100, 32'h1234, 3, 0, 1, 0, "R2");
        run_req(0, 32'h00200, 32'h00FF, 0, 0, 1, 0, "R5");
        // R5 verify failure: 0 bits cannot return to 1
        run_req(0, 32'h00200, 32'h0FFF, 0, 0, 0, 0, "R5");
        // R3 sector erase, then the location programs cleanly
        run_req(1, 32'h00200, 0, 5, 0, 1, 0, "R3");
        run_req(0, 32'h00200, 32'h0FFF, 2, 0, 1, 0, "R3");
        // R3 block and chip erase
        run_req(2, 32'h08000, 0, 4, 0, 1, 0, "R3");
        run_req(3, 32'h00100, 0, 6, 0, 1, 0, "R3");
        // R6 conflicting indicators, confirmed good / rejected
        run_req(0, 32'h00300, 32'h5A5A, 2, 1, 1, 0, "R6");
        run_req(0, 32'h00400, 32'h8421, 2, 2, 0, 0, "R6");
        // R7 timeouts
        run_req(0, 32'h00500, 32'h7777, 0, 3, 0, 1, "R7");
        run_req(3, 32'h00600, 0, 0, 3, 0, 1, "R7");
        // R4 erase polls a value with bit 7 set
        run_req(1, 32'h00800, 0, 1, 0, 1, 0, "R4");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule